// File: doc/BRIEF.md
# Power Mode Wake-Up Controller

This block is the mode sequencer of a processor's clock and power unit. It keeps track of seven operating modes:

- normal at the high clock divisor;
- normal at the low clock divisor;
- doze at the high divisor;
- doze at the low divisor;
- sleep;
- deep-sleep;
- power-down.

Software asks for a low-power mode through a request strobe with a mode code. The block then enters that mode and later brings the core back to normal-high when a wake source that the mode accepts turns up. While in normal or doze mode, the block also moves between the low and high clock divisors by itself. The move depends on interrupt activity, the power-management enable and the clock-switch control bit.

The PLL, the oscillator and the supply are not modelled. They appear only as a lock input and a supply-good input. The whole block runs on the always-on reference clock, so the wake counters keep counting while the PLL is stopped. A one-cycle wake-complete pulse marks the first cycle of normal-high after a wake-up.

Mode codes (output `mode_o` and input `req_mode_i`):

| Code | Mode |
|------|------|
| 0 | normal-high |
| 1 | normal-low |
| 2 | doze-high |
| 3 | doze-low |
| 4 | sleep |
| 5 | deep-sleep |
| 6 | power-down |

Top module: `pwr_wake_ctrl`

## Requirements
- R1: After reset the mode is 0 (normal-high), `pll_en_o` is 1, `div_o` equals `div_hi_i` and `wake_done_o` is 0.
- R2: In mode 0 with no accepted request, the mode becomes 1 (normal-low) one cycle after `clk_sw_i`=1, `pm_en_i`=1, `irq_pend_i`=0 and `async_pend_i`=0 are sampled together. `div_o` equals `div_lo_i` in modes 1 and 3 and equals `div_hi_i` in every other mode.
- R3: In mode 1, `irq_pend_i`=1, `pm_en_i`=0 or `clk_sw_i`=0 returns the mode to 0 in the next cycle, without a wake-complete pulse.
- R4: A request (`req_valid_i`=1) is taken only in mode 0 and only for codes 2, 4, 5 and 6; the mode becomes that code in the next cycle. All other codes, requests made in other modes, and requests whose target mode already sees one of its own wake sources active are ignored.
- R5: Doze-high (2) moves to doze-low (3) when `clk_sw_i`, `pm_en_i` are 1 and `async_pend_i` is 0. Doze-low returns to doze-high when `clk_sw_i` or `pm_en_i` is 0.
- R6: Doze (2, 3) and sleep (4) wake only on `irq_pend_i`. The mode becomes 0 exactly DOZE_LAT (default 3) cycles after the cycle in which the interrupt is sampled.
- R7: In deep-sleep (5) `pll_en_o` is 0 until a wake source is sampled. The wake sources are `irq_pend_i`, `rtc_wake_i`, `pit_wake_i`, `tbase_wake_i` and `dec_wake_i`. From the next cycle `pll_en_o` is 1.
- R8: During a deep-sleep wake, the mode becomes 0 in the cycle after `pll_lock_i` is sampled high. At the latest it becomes 0 DEEP_LAT (default 500) cycles after the wake sample, or DEEP_LAT_1TO1 (default 100) cycles when `one2one_i`=1.
- R9: In power-down (6) `pll_en_o` is 0, and only `ext_wake_i` wakes the block. After it, the block waits for `pwr_good_i`, raises `pll_en_o` and then finishes as in R8.
- R10: `wake_done_o` is a one-cycle pulse in the first mode-0 cycle after a wake from modes 2 to 6, and only then.
- R11: Several wake sources asserted in the same cycle, or held during the wake, give a single wake event and a single `wake_done_o` pulse.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Always-on reference clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid_i | input | 1 | Software mode-entry strobe |
| req_mode_i | input | 3 | Requested mode code |
| clk_sw_i | input | 1 | Clock-switch control: allow low-divisor operation |
| pm_en_i | input | 1 | Power-management enable |
| async_pend_i | input | 1 | Asynchronous interrupt status bits still set |
| div_lo_i | input | DIV_W | Low-frequency divisor |
| div_hi_i | input | DIV_W | High-frequency divisor |
| irq_pend_i | input | 1 | Interrupt pending from the interrupt controller |
| rtc_wake_i | input | 1 | Real-time-clock wake request |
| pit_wake_i | input | 1 | Periodic-timer wake request |
| tbase_wake_i | input | 1 | Time-base wake request |
| dec_wake_i | input | 1 | Decrementer exception |
| ext_wake_i | input | 1 | External wake for power-down |
| pwr_good_i | input | 1 | Supply wake-up handshake |
| pll_lock_i | input | 1 | PLL locked |
| one2one_i | input | 1 | One-to-one clock mode |
| mode_o | output | 3 | Active mode code |
| div_o | output | DIV_W | Selected clock divisor |
| pll_en_o | output | 1 | PLL enable |
| wake_done_o | output | 1 | Wake-complete pulse |

## Verification
The hardest situation to reach is the full-length wake timeout: a deep-sleep or power-down wake that runs the counter to its limit with the lock never arriving. Random stimulus raises the lock input often enough to cut almost every wake short. Directed sequences therefore hold the lock low and count the exact number of cycles to normal-high in both the normal and one-to-one limits. They also drive every wake source in one cycle, to show that a single event is taken. A long constrained-random run with sparse wake sources then compares every output, every cycle, against a bench model.

// File: rtl/pwr_mode_pkg.sv
package pwr_mode_pkg;

  typedef enum logic [2:0] {
    M_NHI  = 3'd0,
    M_NLO  = 3'd1,
    M_DHI  = 3'd2,
    M_DLO  = 3'd3,
    M_SLP  = 3'd4,
    M_DEEP = 3'd5,
    M_PDN  = 3'd6
  } pmode_e;

  typedef enum logic [1:0] {
    W_IDLE   = 2'd0,
    W_SUPPLY = 2'd1,
    W_COUNT  = 2'd2
  } wphase_e;

  typedef struct packed {
    logic irq;
    logic rtc;
    logic pit;
    logic tbase;
    logic dec;
    logic ext;
  } wsrc_t;

  // codes that software may request from normal-high
  function automatic logic req_code_ok(logic [2:0] code);
    return (code == M_DHI) || (code == M_SLP) || (code == M_DEEP) || (code == M_PDN);
  endfunction

  // does the given mode accept any of the active sources as a wake
  function automatic logic wake_hit(logic [2:0] m, wsrc_t s);
    case (m)
      M_DHI, M_DLO, M_SLP: return s.irq;
      M_DEEP:              return s.irq | s.rtc | s.pit | s.tbase | s.dec;
      M_PDN:               return s.ext;
      default:             return 1'b0;
    endcase
  endfunction

  // low divisor allowed (normal mode rule)
  function automatic logic low_ok(logic sw, logic pm, logic irq, logic apend);
    return sw & pm & ~irq & ~apend;
  endfunction

  // wake counter reached its limit after this edge
  function automatic logic lat_reached(int unsigned elapsed, int unsigned limit);
    return (elapsed + 1) >= limit;
  endfunction

endpackage

// File: rtl/pwr_wake_decode.sv
module pwr_wake_decode
  import pwr_mode_pkg::*;
(
  input  logic [2:0] mode_i,
  input  logic [2:0] req_mode_i,
  input  wsrc_t      src_i,
  output logic       hit_o,
  output logic       req_block_o
);
  assign hit_o       = wake_hit(mode_i, src_i);
  assign req_block_o = wake_hit(req_mode_i, src_i);
endmodule

// File: rtl/pwr_lat_timer.sv
module pwr_lat_timer
  import pwr_mode_pkg::*;
#(
  parameter int CNT_W = 9
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run_i,
  input  logic [CNT_W-1:0] limit_i,
  output logic             expire_o
);
  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (!run_i) cnt_q <= '0;
    else             cnt_q <= cnt_q + 1'b1;
  end

  assign expire_o = run_i && lat_reached(int'(cnt_q), int'(limit_i));
endmodule

// File: rtl/pwr_div_sel.sv
module pwr_div_sel
  import pwr_mode_pkg::*;
#(
  parameter int DIV_W = 4
) (
  input  logic [2:0]       mode_i,
  input  logic [DIV_W-1:0] div_lo_i,
  input  logic [DIV_W-1:0] div_hi_i,
  output logic [DIV_W-1:0] div_o
);
  assign div_o = ((mode_i == M_NLO) || (mode_i == M_DLO)) ? div_lo_i : div_hi_i;
endmodule

// File: rtl/pwr_wake_ctrl.sv
module pwr_wake_ctrl
  import pwr_mode_pkg::*;
#(
  parameter int DIV_W         = 4,
  parameter int DOZE_LAT      = 3,
  parameter int DEEP_LAT      = 500,
  parameter int DEEP_LAT_1TO1 = 100
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req_valid_i,
  input  logic [2:0]       req_mode_i,
  input  logic             clk_sw_i,
  input  logic             pm_en_i,
  input  logic             async_pend_i,
  input  logic [DIV_W-1:0] div_lo_i,
  input  logic [DIV_W-1:0] div_hi_i,
  input  logic             irq_pend_i,
  input  logic             rtc_wake_i,
  input  logic             pit_wake_i,
  input  logic             tbase_wake_i,
  input  logic             dec_wake_i,
  input  logic             ext_wake_i,
  input  logic             pwr_good_i,
  input  logic             pll_lock_i,
  input  logic             one2one_i,
  output logic [2:0]       mode_o,
  output logic [DIV_W-1:0] div_o,
  output logic             pll_en_o,
  output logic             wake_done_o
);
  localparam int CNT_W = $clog2(DEEP_LAT + 1);
  localparam logic [CNT_W-1:0] LIM_DOZE = CNT_W'(DOZE_LAT);
  localparam logic [CNT_W-1:0] LIM_DEEP = CNT_W'(DEEP_LAT);
  localparam logic [CNT_W-1:0] LIM_1TO1 = CNT_W'(DEEP_LAT_1TO1);

  pmode_e  mode_q, mode_d;
  wphase_e phase_q, phase_d;
  logic    done_q, done_d;

  wsrc_t src;
  assign src = '{irq: irq_pend_i, rtc: rtc_wake_i, pit: pit_wake_i,
                 tbase: tbase_wake_i, dec: dec_wake_i, ext: ext_wake_i};

  // named internal events, used by the checker
  logic wake_evt, req_block, req_take, lo_ok, lock_mode, expire, wake_exit, wake_busy;
  logic [CNT_W-1:0] limit;

  pwr_wake_decode u_dec (
    .mode_i(mode_q), .req_mode_i(req_mode_i), .src_i(src),
    .hit_o(wake_evt), .req_block_o(req_block)
  );

  assign lock_mode = (mode_q == M_DEEP) || (mode_q == M_PDN);
  assign limit     = lock_mode ? (one2one_i ? LIM_1TO1 : LIM_DEEP) : LIM_DOZE;
  assign wake_busy = (phase_q != W_IDLE);

  pwr_lat_timer #(.CNT_W(CNT_W)) u_tmr (
    .clk(clk), .rst_n(rst_n), .run_i(phase_q == W_COUNT),
    .limit_i(limit), .expire_o(expire)
  );

  assign lo_ok     = low_ok(clk_sw_i, pm_en_i, irq_pend_i, async_pend_i);
  assign req_take  = (mode_q == M_NHI) && !wake_busy && req_valid_i
                     && req_code_ok(req_mode_i) && !req_block;
  assign wake_exit = (phase_q == W_COUNT) && (expire || (lock_mode && pll_lock_i));

  always_comb begin
    mode_d  = mode_q;
    phase_d = phase_q;
    done_d  = 1'b0;
    unique case (phase_q)
      W_COUNT: begin
        if (wake_exit) begin
          mode_d  = M_NHI;
          phase_d = W_IDLE;
          done_d  = 1'b1;
        end
      end
      W_SUPPLY: begin
        if (pwr_good_i) phase_d = W_COUNT;
      end
      default: begin
        unique case (mode_q)
          M_NHI: begin
            if (req_take)   mode_d = pmode_e'(req_mode_i);
            else if (lo_ok) mode_d = M_NLO;
          end
          M_NLO: begin
            if (irq_pend_i || !pm_en_i || !clk_sw_i) mode_d = M_NHI;
          end
          M_DHI, M_DLO, M_SLP, M_DEEP: begin
            if (wake_evt) phase_d = W_COUNT;
            else if (mode_q == M_DHI && clk_sw_i && pm_en_i && !async_pend_i)
              mode_d = M_DLO;
            else if (mode_q == M_DLO && !(clk_sw_i && pm_en_i))
              mode_d = M_DHI;
          end
          M_PDN: begin
            if (wake_evt) phase_d = W_SUPPLY;
          end
          default: mode_d = M_NHI;
        endcase
      end
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q  <= M_NHI;
      phase_q <= W_IDLE;
      done_q  <= 1'b0;
    end else begin
      mode_q  <= mode_d;
      phase_q <= phase_d;
      done_q  <= done_d;
    end
  end

  pwr_div_sel #(.DIV_W(DIV_W)) u_div (
    .mode_i(mode_q), .div_lo_i(div_lo_i), .div_hi_i(div_hi_i), .div_o(div_o)
  );

  assign mode_o      = mode_q;
  assign wake_done_o = done_q;
  assign pll_en_o    = !(((mode_q == M_DEEP) && (phase_q == W_IDLE)) ||
                         ((mode_q == M_PDN) && (phase_q != W_COUNT)));
endmodule

// File: rtl/pwr_wake_ctrl_chk.sv
module pwr_wake_ctrl_chk (
  input logic       clk,
  input logic       rst_n,
  input logic [2:0] mode_o,
  input logic       pll_en_o,
  input logic       wake_done_o,
  input logic       irq_pend_i,
  input logic       pm_en_i,
  input logic       req_valid_i,
  input logic       req_block,
  input logic       wake_busy
);
  AST_DONE_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    wake_done_o |=> !wake_done_o);                                           // R10
  AST_DONE_IN_NHI: assert property (@(posedge clk) disable iff (!rst_n)
    wake_done_o |-> (mode_o == 3'd0));                                       // R10
  AST_DEEP_PLL_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_o == 3'd5 && !wake_busy) |-> !pll_en_o);                           // R7
  AST_LO_EXIT: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_o == 3'd1 && (irq_pend_i || !pm_en_i)) |=> (mode_o == 3'd0));      // R3
  AST_REQ_BLOCKED: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_o == 3'd0 && req_valid_i && req_block) |=> (mode_o inside {3'd0, 3'd1})); // R4
  AST_DOZE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    ((mode_o == 3'd2 || mode_o == 3'd3) && !irq_pend_i && !wake_busy)
      |=> (mode_o inside {3'd2, 3'd3}));                                     // R6
endmodule

bind pwr_wake_ctrl pwr_wake_ctrl_chk u_chk (
  .clk(clk), .rst_n(rst_n), .mode_o(mode_o), .pll_en_o(pll_en_o),
  .wake_done_o(wake_done_o), .irq_pend_i(irq_pend_i), .pm_en_i(pm_en_i),
  .req_valid_i(req_valid_i), .req_block(req_block), .wake_busy(wake_busy)
);

// File: tb/tb_pwr_wake_ctrl.sv
`timescale 1ns/1ps
module tb_pwr_wake_ctrl;
  localparam int DW = 4;
  localparam int L_DOZE = 3, L_DEEP = 500, L_1TO1 = 100;

  logic clk = 0, rst_n = 0;
  logic req_valid = 0; logic [2:0] req_mode = 0;
  logic clk_sw = 0, pm_en = 0, async_pend = 0;
  logic [DW-1:0] div_lo = 4'h3, div_hi = 4'hC;
  logic irq = 0, rtc = 0, pit = 0, tbw = 0, dec = 0, ext = 0;
  logic pwr_good = 0, pll_lock = 0, one2one = 0;
  logic [2:0] mode; logic [DW-1:0] div; logic pll_en, done;

  int checks = 0, fails = 0;
  bit finished = 0;

  always #10 clk = ~clk;

  pwr_wake_ctrl dut (
    .clk(clk), .rst_n(rst_n), .req_valid_i(req_valid), .req_mode_i(req_mode),
    .clk_sw_i(clk_sw), .pm_en_i(pm_en), .async_pend_i(async_pend),
    .div_lo_i(div_lo), .div_hi_i(div_hi), .irq_pend_i(irq), .rtc_wake_i(rtc),
    .pit_wake_i(pit), .tbase_wake_i(tbw), .dec_wake_i(dec), .ext_wake_i(ext),
    .pwr_good_i(pwr_good), .pll_lock_i(pll_lock), .one2one_i(one2one),
    .mode_o(mode), .div_o(div), .pll_en_o(pll_en), .wake_done_o(done)
  );

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  // ---------- bench model, written from the requirements ----------
  function automatic bit src_ok(int m);
    case (m)
      2, 3, 4: return irq;
      5:       return irq | rtc | pit | tbw | dec;
      6:       return ext;
      default: return 0;
    endcase
  endfunction

  int mm = 0, mp = 0, mc = 0; bit md = 0;   // mode, phase(0 idle,1 supply,2 count), elapsed, done

  always @(posedge clk) begin
    if (!rst_n) begin
      mm <= 0; mp <= 0; mc <= 0; md <= 0;
    end else begin
      int nm, np, nc, lim; bit nd, lockm;
      nm = mm; np = mp; nc = 0; nd = 0;
      lockm = (mm == 5 || mm == 6);
      lim = lockm ? (one2one ? L_1TO1 : L_DEEP) : L_DOZE;
      if (mp == 2) begin
        nc = mc + 1;
        if (nc >= lim || (lockm && pll_lock)) begin nm = 0; np = 0; nd = 1; nc = 0; end
      end else if (mp == 1) begin
        if (pwr_good) np = 2;
      end else begin
        case (mm)
          0: if (req_valid && (req_mode == 2 || req_mode == 4 || req_mode == 5 || req_mode == 6)
                 && !src_ok(int'(req_mode))) nm = int'(req_mode);
             else if (clk_sw && pm_en && !irq && !async_pend) nm = 1;
          1: if (irq || !pm_en || !clk_sw) nm = 0;
          2, 3, 4: if (irq) np = 2;
                   else if (mm == 2 && clk_sw && pm_en && !async_pend) nm = 3;
                   else if (mm == 3 && !(clk_sw && pm_en)) nm = 2;
          5: if (src_ok(5)) np = 2;
          6: if (ext) np = 1;
          default: nm = 0;
        endcase
      end
      mm <= nm; mp <= np; mc <= nc; md <= nd;
    end
  end

  always @(posedge clk) begin
    #5;
    if (rst_n && !finished) begin
      chk("R4 model mode", mode, mm);
      chk("R7 model pll_en", pll_en, !((mm == 5 && mp == 0) || (mm == 6 && mp != 2)));
      chk("R2 model div_sel", div, (mm == 1 || mm == 3) ? div_lo : div_hi);
      chk("R10 model wake_done", done, md);
    end
  end

  // ---------- helpers ----------
  task automatic tick(); @(negedge clk); endtask

  task automatic request(input logic [2:0] code);
    req_valid = 1; req_mode = code; tick(); req_valid = 0;
  endtask

  task automatic count_exit(input string tag, input int exp);
    int n = 0;
    while (mode != 0 && n < 2000) begin tick(); n++; end
    chk(tag, n, exp);
  endtask

  initial begin : watchdog
    #(20 * 150000);
    fails++;
    $display("FAIL watchdog expired");
    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin : main
    int pulses;
    void'($urandom(32'd1234));
    repeat (3) tick();
    chk("R1 reset mode", mode, 0); chk("R1 reset pll_en", pll_en, 1);
    chk("R1 reset div", div, div_hi); chk("R1 reset done", done, 0);
    rst_n = 1; tick();
    chk("R1 after release mode", mode, 0);

    // R2 / R3 normal-low
    pm_en = 1; clk_sw = 1; tick();
    chk("R2 enter normal-low", mode, 1); chk("R2 low divisor", div, div_lo);
    irq = 1; tick();
    chk("R3 irq exits normal-low", mode, 0); chk("R10 no pulse on R3 exit", done, 0);
    irq = 0; pm_en = 0; tick();
    chk("R3 pm_en off stays high", mode, 0);

    // R4 ignored requests
    rtc = 1; request(3'd5); rtc = 0;
    chk("R4 deep request blocked by rtc", mode, 0);
    request(3'd7);
    chk("R4 illegal code ignored", mode, 0);

    // R7 / R8 deep timeout
    request(3'd5);
    chk("R7 deep entered", mode, 5); chk("R7 pll off in deep", pll_en, 0);
    repeat (3) tick();
    chk("R7 deep holds without source", mode, 5);
    rtc = 1; tick(); rtc = 0;
    chk("R7 pll on after wake", pll_en, 1);
    count_exit("R8 deep timeout cycles", L_DEEP);
    chk("R10 done pulse", done, 1); tick(); chk("R10 done drops", done, 0);

    one2one = 1; request(3'd5);
    dec = 1; tick(); dec = 0;
    count_exit("R8 one-to-one timeout cycles", L_1TO1);
    one2one = 0;

    request(3'd5); tbw = 1; tick(); tbw = 0;
    repeat (9) tick();
    chk("R8 still waking before lock", mode, 5);
    pll_lock = 1; tick(); pll_lock = 0;
    chk("R8 exit on lock", mode, 0);

    // R6 doze and sleep
    request(3'd2); chk("R4 doze entered", mode, 2);
    irq = 1; tick(); irq = 0;
    count_exit("R6 doze wake latency", L_DOZE);
    request(3'd4); rtc = 1; pit = 1; tick(); tick();
    chk("R6 sleep ignores timers", mode, 4);
    rtc = 0; pit = 0; irq = 1; tick(); irq = 0;
    count_exit("R6 sleep wake latency", L_DOZE);

    // R5 doze toggling
    request(3'd2);
    pm_en = 1; clk_sw = 1; tick();
    chk("R5 doze-low", mode, 3); chk("R5 doze-low divisor", div, div_lo);
    clk_sw = 0; tick();
    chk("R5 back to doze-high", mode, 2);
    irq = 1; tick(); irq = 0;
    count_exit("R6 doze wake after toggle", L_DOZE);
    pm_en = 0; tick();

    // R9 power-down
    request(3'd6);
    chk("R9 power-down entered", mode, 6); chk("R9 pll off", pll_en, 0);
    irq = 1; rtc = 1; tick(); irq = 0; rtc = 0;
    repeat (5) tick();
    chk("R9 ignores irq/rtc", mode, 6);
    ext = 1; tick(); ext = 0;
    repeat (20) tick();
    chk("R9 pll off awaiting supply", pll_en, 0);
    pwr_good = 1; tick(); pwr_good = 0;
    chk("R9 pll on after supply", pll_en, 1);
    pll_lock = 1; tick(); pll_lock = 0;
    chk("R9 exit on lock", mode, 0); chk("R10 done after power-down", done, 1);

    // R11 all sources at once
    request(3'd5);
    irq = 1; rtc = 1; pit = 1; tbw = 1; dec = 1;
    pulses = 0;
    for (int i = 0; i < 600; i++) begin tick(); if (done) pulses++; end
    chk("R11 single wake event", pulses, 1);
    irq = 0; rtc = 0; pit = 0; tbw = 0; dec = 0; tick();

    // constrained random phase, checked by the model every cycle
    pm_en = 1; clk_sw = 1;
    for (int i = 0; i < 20000; i++) begin
      irq        = ($urandom_range(0, 39) == 0);
      rtc        = ($urandom_range(0, 199) == 0);
      pit        = ($urandom_range(0, 199) == 0);
      tbw        = ($urandom_range(0, 199) == 0);
      dec        = ($urandom_range(0, 199) == 0);
      ext        = ($urandom_range(0, 99) == 0);
      pwr_good   = ($urandom_range(0, 3) == 0);
      pll_lock   = ($urandom_range(0, 99) == 0);
      async_pend = ($urandom_range(0, 7) == 0);
      req_valid  = ($urandom_range(0, 9) == 0);
      req_mode   = 3'($urandom_range(0, 7));
      if ($urandom_range(0, 49) == 0) pm_en = ~pm_en;
      if ($urandom_range(0, 49) == 0) clk_sw = ~clk_sw;
      if ($urandom_range(0, 299) == 0) one2one = ~one2one;
      tick();
    end
    tick();
    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule